// File: doc/BRIEF.md
# Byte-Lane DRAM Strobe and Output Control

This block is the device-side control logic of a sixteen-bit dynamic memory whose column strobe is split into one strobe per byte lane. All control pins (row strobe, the lane column strobes, write enable, output enable) and the multiplexed address are sampled on a fast local clock. From the order in which these pins change, the block works out which kind of memory cycle is in progress. It also latches the row and column address and produces the per-lane write pulses and per-lane data-pin drive enables that the storage array and the pad ring use.

The lane strobes are merged into one internal column strobe. That strobe starts when the first lane strobe falls and ends only when the last lane strobe has returned high. Each lane strobe still gates only its own byte's output drivers. Whether a write is early, late or read-modify-write depends on when write enable falls compared with the column strobe. When two lanes would use different write modes within one column strobe, the block flags a protocol error and suppresses the write.

Every output is registered. An edge on an input pin shows up on the outputs two clock edges after the input changes.

Top module: `byte_lane_dram_ctrl`

## Requirements
- R1: `col_active` is high while at least one lane strobe is low. It goes high when the first lane strobe falls and stays high until every lane strobe is high again.
- R2: `drv_en[i]` can be high only while lane strobe `cas_n[i]` is low. Bit 0 is the low byte (data bits 7..0) and bit 1 is the high byte (data bits 15..8).
- R3: A row-strobe fall that is not a refresh-by-strobe-order loads `row_addr` from `addr`. The first lane-strobe fall while the row is open loads `col_addr`. A second lane falling in the same column strobe does not reload it.
- R4: If write enable is low when a lane strobe falls, the cycle is an early write (`cyc_type` = 2). That lane gets a write pulse at its fall, and no lane drives the data pins.
- R5: In a read (`cyc_type` = 1), a fall of write enable pulses `wr_stb` for every lane whose strobe is low. The type becomes late write (3) if output enable is high at that moment, or read-modify-write (4) if it is low. In read-modify-write the read data stays driven while the strobe and output enable stay low.
- R6: Each write event gives a `wr_stb` pulse exactly one clock wide per lane.
- R7: A row-strobe fall with all lane strobes high gives row-only refresh (`cyc_type` = 5). A row-strobe fall with any lane strobe already low gives strobe-order refresh (6), which leaves `row_addr` unchanged. Neither refresh type produces write pulses or drive enables.
- R8: While output enable is high, no lane drives the data pins.
- R9: A lane falling within an active column strobe in a write mode different from the first lane sets `proto_err`, and no write pulse follows while the error is set. The error clears once all lane strobes are high.
- R10: With the row strobe held low, a new column strobe reclassifies the cycle and loads a new column. Returning the row strobe high sets `cyc_type` to idle (0).
- R11: After reset, `cyc_type` is idle, `row_addr` is zero, and `col_active`, `wr_stb`, `drv_en` and `proto_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | LANES | Per-lane column strobes, active low, bit 0 = low byte |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| row_addr | output | ADDR_W | Latched row address |
| col_addr | output | ADDR_W | Latched column address |
| cyc_type | output | 3 | Cycle class: 0 idle, 1 read, 2 early write, 3 late write, 4 read-modify-write, 5 row-only refresh, 6 strobe-order refresh |
| col_active | output | 1 | Merged internal column strobe, active high |
| wr_stb | output | LANES | One-clock write pulse per lane |
| drv_en | output | LANES | Per-lane data-pin drive enable |
| proto_err | output | 1 | Lanes mixed write modes within one column strobe |

## Verification
The bench targets these corner cases:
- Staggered lane strobes. A design that ends the internal strobe on the first rise, or that re-latches the column on the second fall, shows a wrong `col_active` or `col_addr`.
- Write enable falling after a single-lane read. A design that writes both bytes damages the other byte in the bench memory. A design that drops the drive in read-modify-write shows `drv_en` low.
- Refresh with write enable low. A design that does not tell the strobe orders apart raises write pulses there.
- A lane joining an early write with write enable high. A design without the mixing rule writes that lane or never raises `proto_err`.

// File: rtl/dram_lane_pkg.sv
// Shared types for the byte-lane DRAM strobe controller.
// Assumes a 3-bit cycle class is enough for all cycle kinds.
package dram_lane_pkg;
    typedef enum logic [2:0] {
        CYC_IDLE     = 3'd0,
        CYC_READ     = 3'd1,
        CYC_EARLY_WR = 3'd2,
        CYC_LATE_WR  = 3'd3,
        CYC_RMW      = 3'd4,
        CYC_RAS_ONLY = 3'd5,
        CYC_CBR      = 3'd6
    } cyc_e;
endpackage

// File: rtl/strobe_sampler.sv
// Two-stage sampler for active-low control pins: the current sample
// and the one before it, so edges can be found downstream.
// Assumes the pins are synchronous to clk or already synchronised.
module strobe_sampler #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    output logic [W-1:0] cur,
    output logic [W-1:0] prv
);
    // Shift the pin samples; reset to the inactive (high) level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '1;
            prv <= '1;
        end else begin
            cur <= pins;
            prv <= cur;
        end
    end
endmodule

// File: rtl/lane_merge.sv
// Merges per-lane column strobes into one internal strobe and
// detects per-lane falls and the first fall of a column strobe.
// Assumes active-low strobes in sampled form (current and previous).
module lane_merge #(
    parameter int LANES = 2
) (
    input  logic [LANES-1:0] cas_cur,
    input  logic [LANES-1:0] cas_prv,
    output logic [LANES-1:0] lane_low,
    output logic [LANES-1:0] lane_fall,
    output logic             any_low,
    output logic             first_fall
);
    logic any_low_prv;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Per-lane level and falling edge.
        assign lane_low[i]  = ~cas_cur[i];
        assign lane_fall[i] = ~cas_cur[i] & cas_prv[i];
    end

    // Merged strobe: active while any lane is low.
    assign any_low     = |lane_low;
    assign any_low_prv = ~(&cas_prv);
    assign first_fall  = any_low & ~any_low_prv;
endmodule

// File: rtl/cycle_ctrl.sv
// Cycle classifier: latches row and column, classifies the cycle from
// strobe order, raises write pulses and per-lane drive enables, and
// flags mixed write modes between lanes within one column strobe.
// Assumes edge information from lane_merge and sampled pins.
module cycle_ctrl
    import dram_lane_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_cur,
    input  logic              ras_prv,
    input  logic              we_cur,
    input  logic              we_prv,
    input  logic              oe_cur,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [LANES-1:0]  lane_low,
    input  logic [LANES-1:0]  lane_fall,
    input  logic              any_low,
    input  logic              first_fall,
    output logic [ADDR_W-1:0] row,
    output logic [ADDR_W-1:0] col,
    output cyc_e              cyc,
    output logic              col_act,
    output logic [LANES-1:0]  wr,
    output logic [LANES-1:0]  drv,
    output logic              err
);
    cyc_e              cyc_n;
    logic [ADDR_W-1:0] row_n, col_n;
    logic [LANES-1:0]  wr_n, drv_n;
    logic              err_n, mix, ras_fall, we_fall, row_open, reads;

    assign ras_fall = ras_prv & ~ras_cur;
    assign we_fall  = we_prv & ~we_cur;
    assign row_open = (cyc != CYC_IDLE) && (cyc != CYC_CBR);

    // Next cycle class, addresses, error and write pulses.
    always_comb begin
        cyc_n = cyc;
        row_n = row;
        col_n = col;
        err_n = err;
        wr_n  = '0;
        mix   = 1'b0;
        if (ras_cur) begin
            cyc_n = CYC_IDLE;
            err_n = 1'b0;
        end else if (ras_fall) begin
            err_n = 1'b0;
            if (any_low) begin
                cyc_n = CYC_CBR;
            end else begin
                cyc_n = CYC_RAS_ONLY;
                row_n = addr_q;
            end
        end else if (row_open) begin
            if (first_fall) begin
                col_n = addr_q;
                err_n = 1'b0;
                if (we_cur) begin
                    cyc_n = CYC_READ;
                end else begin
                    cyc_n = CYC_EARLY_WR;
                    wr_n  = lane_fall;
                end
            end else if (any_low) begin
                if (|lane_fall)
                    mix = (cyc == CYC_EARLY_WR) ? we_cur :
                          (cyc == CYC_READ)     ? ~we_cur : 1'b1;
                if (mix)
                    err_n = 1'b1;
                if (!err && !mix) begin
                    if (cyc == CYC_EARLY_WR) begin
                        wr_n = lane_fall;
                    end else if (cyc == CYC_READ && we_fall) begin
                        cyc_n = oe_cur ? CYC_LATE_WR : CYC_RMW;
                        wr_n  = lane_low;
                    end
                end
            end else begin
                err_n = 1'b0;
            end
        end
    end

    // Drive enables: read-type cycles only, per lane, gated by OE.
    assign reads = (cyc_n == CYC_READ) || (cyc_n == CYC_LATE_WR) || (cyc_n == CYC_RMW);
    assign drv_n = (reads && !err_n && !oe_cur) ? lane_low : '0;

    // Register all outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc     <= CYC_IDLE;
            row     <= '0;
            col     <= '0;
            err     <= 1'b0;
            wr      <= '0;
            drv     <= '0;
            col_act <= 1'b0;
        end else begin
            cyc     <= cyc_n;
            row     <= row_n;
            col     <= col_n;
            err     <= err_n;
            wr      <= wr_n;
            drv     <= drv_n;
            col_act <= any_low;
        end
    end
endmodule

// File: rtl/byte_lane_dram_ctrl.sv
// Top of the byte-lane DRAM strobe controller: samples the pins,
// merges the lane strobes and classifies each memory cycle.
// Assumes pins synchronous to clk; outputs lag the pins by two edges.
module byte_lane_dram_ctrl
    import dram_lane_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic [LANES-1:0]  cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] row_addr,
    output logic [ADDR_W-1:0] col_addr,
    output logic [2:0]        cyc_type,
    output logic              col_active,
    output logic [LANES-1:0]  wr_stb,
    output logic [LANES-1:0]  drv_en,
    output logic              proto_err
);
    localparam int CTL_W = LANES + 2;

    logic [CTL_W-1:0]  ctl_cur, ctl_prv;
    logic [ADDR_W-1:0] addr_q;
    logic              oe_q;
    logic [LANES-1:0]  lane_low, lane_fall;
    logic              any_low, first_fall;
    cyc_e              cyc;

    strobe_sampler #(.W(CTL_W)) u_smp (
        .clk(clk), .rst_n(rst_n), .pins({we_n, ras_n, cas_n}),
        .cur(ctl_cur), .prv(ctl_prv)
    );

    // Sample address and output enable alongside the strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            oe_q   <= 1'b1;
        end else begin
            addr_q <= addr;
            oe_q   <= oe_n;
        end
    end

    lane_merge #(.LANES(LANES)) u_merge (
        .cas_cur(ctl_cur[LANES-1:0]), .cas_prv(ctl_prv[LANES-1:0]),
        .lane_low(lane_low), .lane_fall(lane_fall),
        .any_low(any_low), .first_fall(first_fall)
    );

    cycle_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ras_cur(ctl_cur[LANES]), .ras_prv(ctl_prv[LANES]),
        .we_cur(ctl_cur[LANES+1]), .we_prv(ctl_prv[LANES+1]),
        .oe_cur(oe_q), .addr_q(addr_q),
        .lane_low(lane_low), .lane_fall(lane_fall),
        .any_low(any_low), .first_fall(first_fall),
        .row(row_addr), .col(col_addr), .cyc(cyc), .col_act(col_active),
        .wr(wr_stb), .drv(drv_en), .err(proto_err)
    );

    assign cyc_type = cyc;
endmodule

// File: rtl/byte_lane_dram_ctrl_chk.sv
// Protocol checker for byte_lane_dram_ctrl, attached by bind.
// Assumes the two-edge pin-to-output latency of the top module.
module byte_lane_dram_ctrl_chk
    import dram_lane_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ras_n,
    input logic [LANES-1:0]  cas_n,
    input logic              oe_n,
    input logic [ADDR_W-1:0] col_addr,
    input logic [2:0]        cyc_type,
    input logic              col_active,
    input logic [LANES-1:0]  wr_stb,
    input logic [LANES-1:0]  drv_en,
    input logic              proto_err
);
    AST_COL_STROBE_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        col_active == !$past(&cas_n, 2)); // R1
    AST_COL_CHANGE_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (col_addr != $past(col_addr)) |-> (cyc_type == CYC_READ || cyc_type == CYC_EARLY_WR)); // R3
    AST_EARLY_WR_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type == CYC_EARLY_WR) |-> (drv_en == '0)); // R4
    AST_REFRESH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type == CYC_RAS_ONLY || cyc_type == CYC_CBR) |-> (wr_stb == '0 && drv_en == '0)); // R7
    AST_OE_HIGH_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(oe_n, 2) |-> (drv_en == '0)); // R8
    AST_ERR_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> (wr_stb == '0)); // R9
    AST_RAS_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ras_n, 2) |-> (cyc_type == CYC_IDLE)); // R10

    for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
        AST_LANE_DRIVE_OWN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
            drv_en[i] |-> !$past(cas_n[i], 2)); // R2
        AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            wr_stb[i] |=> !wr_stb[i]); // R6
    end
endmodule

bind byte_lane_dram_ctrl byte_lane_dram_ctrl_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .oe_n(oe_n),
    .col_addr(col_addr), .cyc_type(cyc_type), .col_active(col_active),
    .wr_stb(wr_stb), .drv_en(drv_en), .proto_err(proto_err)
);

// File: tb/byte_lane_dram_ctrl_test.sv
// Directed bench: one task per scenario, with a small word memory
// written by the write pulses.
module byte_lane_dram_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ras_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [1:0]  cas_n = 2'b11;
    logic [9:0]  addr = '0;
    logic [9:0]  row_addr, col_addr;
    logic [2:0]  cyc_type;
    logic        col_active, proto_err;
    logic [1:0]  wr_stb, drv_en;
    logic [15:0] wdata = '0;
    logic [15:0] mem [DEPTH];
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    byte_lane_dram_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .row_addr(row_addr), .col_addr(col_addr),
        .cyc_type(cyc_type), .col_active(col_active), .wr_stb(wr_stb),
        .drv_en(drv_en), .proto_err(proto_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bench storage array: per-lane byte writes on the write pulses.
    always @(posedge clk) begin
        for (int i = 0; i < 2; i++)
            if (wr_stb[i]) mem[col_addr[3:0]][8*i +: 8] <= wdata[8*i +: 8];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic apply(input logic r, input logic [1:0] c, input logic w,
                         input logic o, input logic [9:0] a);
        ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a;
        step(2);
    endtask

    task automatic t_reset;
        chk("R11 cyc", cyc_type, 0);
        chk("R11 row", row_addr, 0);
        chk("R11 outputs", {col_active, wr_stb, drv_en, proto_err}, 0);
    endtask

    task automatic t_ras_only;
        apply(0, 2'b11, 1, 1, 10'h155);
        chk("R7 row-only type", cyc_type, 5);
        chk("R3 row latch", row_addr, 10'h155);
        chk("R7 no drive", drv_en, 0);
        apply(1, 2'b11, 1, 1, 0);
        chk("R10 idle", cyc_type, 0);
    endtask

    task automatic t_cbr;
        apply(1, 2'b00, 1, 0, 10'h2AA);
        chk("R1 strobe active", col_active, 1);
        apply(0, 2'b00, 0, 0, 10'h2AA);
        chk("R7 strobe-order type", cyc_type, 6);
        chk("R7 row kept", row_addr, 10'h155);
        chk("R7 quiet", {wr_stb, drv_en}, 0);
        apply(1, 2'b11, 1, 1, 0);
    endtask

    task automatic t_early_word;
        apply(0, 2'b11, 0, 1, 10'h0A0);
        wdata = 16'hA55A;
        apply(0, 2'b00, 0, 1, 10'd3);
        chk("R4 word write pulse", wr_stb, 2'b11);
        chk("R4 early type", cyc_type, 2);
        chk("R4 undriven", drv_en, 0);
        chk("R3 column latch", col_addr, 3);
        step(1);
        chk("R6 pulse ends", wr_stb, 0);
        chk("R4 memory word", mem[3], 16'hA55A);
        apply(1, 2'b11, 1, 1, 0);
    endtask

    task automatic t_byte_read;
        apply(0, 2'b11, 1, 1, 10'h0A0);
        apply(0, 2'b11, 1, 0, 10'h0A0);
        chk("R2 no strobe no drive", drv_en, 0);
        apply(0, 2'b10, 1, 0, 10'd3);
        chk("R2 low lane only", drv_en, 2'b01);
        chk("R1 read type", cyc_type, 1);
        apply(0, 2'b00, 1, 0, 10'd7);
        chk("R2 both lanes", drv_en, 2'b11);
        chk("R3 no relatch", col_addr, 3);
        apply(0, 2'b01, 1, 0, 10'd7);
        chk("R1 held by last lane", col_active, 1);
        chk("R2 high lane only", drv_en, 2'b10);
        apply(0, 2'b01, 1, 1, 10'd7);
        chk("R8 OE high undriven", drv_en, 0);
        apply(0, 2'b11, 1, 1, 10'd7);
        chk("R1 ends on last rise", col_active, 0);
        apply(1, 2'b11, 1, 1, 0);
    endtask

    task automatic t_late_write;
        apply(0, 2'b11, 1, 1, 10'h0A0);
        wdata = 16'h1234;
        apply(0, 2'b01, 1, 1, 10'd3);
        chk("R5 read before WE", cyc_type, 1);
        apply(0, 2'b01, 0, 1, 10'd3);
        chk("R5 late pulse high lane", wr_stb, 2'b10);
        chk("R5 late type", cyc_type, 3);
        step(1);
        chk("R5 only high byte", mem[3], 16'h125A);
        apply(1, 2'b11, 1, 1, 0);
    endtask

    task automatic t_rmw;
        apply(0, 2'b11, 1, 0, 10'h0A0);
        apply(0, 2'b00, 1, 0, 10'd6);
        chk("R2 read drive", drv_en, 2'b11);
        apply(0, 2'b00, 0, 0, 10'd6);
        chk("R5 rmw pulse", wr_stb, 2'b11);
        chk("R5 rmw type", cyc_type, 4);
        chk("R5 rmw still driven", drv_en, 2'b11);
        step(1);
        chk("R6 single pulse", wr_stb, 0);
        apply(1, 2'b11, 1, 1, 0);
    endtask

    task automatic t_mix_page;
        apply(0, 2'b11, 1, 1, 10'h0A0);
        wdata = 16'hBEEF;
        apply(0, 2'b10, 0, 1, 10'd9);
        chk("R4 low lane early", wr_stb, 2'b01);
        apply(0, 2'b10, 1, 1, 10'd9);
        apply(0, 2'b00, 1, 1, 10'd9);
        chk("R9 error flagged", proto_err, 1);
        chk("R9 no write", wr_stb, 0);
        step(1);
        chk("R9 high byte untouched", mem[9], 16'h00EF);
        apply(0, 2'b11, 1, 1, 10'd9);
        chk("R9 error clears", proto_err, 0);
        apply(0, 2'b01, 1, 0, 10'd12);
        chk("R10 page reclassify", cyc_type, 1);
        chk("R10 page new column", col_addr, 12);
        chk("R9 read after precharge", {proto_err, drv_en}, 3'b010);
        apply(1, 2'b11, 1, 1, 0);
        chk("R10 row strobe high idle", cyc_type, 0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_ras_only();
        t_cbr();
        t_early_word();
        t_byte_read();
        t_late_write();
        t_rmw();
        t_mix_page();
        finish_run();
    end
endmodule